// File: doc/BRIEF.md
# Bit-Prefix Instruction Executor

This unit carries out a single opcode from the bit-manipulation page of an 8-bit processor's instruction set. A 3-bit operand field picks one of seven byte registers or a byte in memory. The top two opcode bits choose among four groups: rotate/shift, bit test, bit clear and bit set. Register operands are read and written through a register-file port in one execution cycle. A memory operand goes through read, modify and write states on a synchronous memory port, at the address the surrounding CPU supplies.

In indexed mode the operand is always the memory byte. The modified byte is also copied into the register that the low opcode field names. On completion the unit pulses `done` and reports how many machine states the instruction cost. Flags are read from, and written back to, the CPU's flag register through a dedicated port.

FSM states: `ST_IDLE` waits for `start`. `ST_REG_EXEC` reads, computes and writes a register operand. `ST_MEM_READ` issues the memory read. `ST_MEM_MODIFY` captures the returned byte. `ST_MEM_WRITE` stores the result and copies it to a register when required. Transitions:
- IDLE→REG_EXEC on `start` with a register operand.
- IDLE→MEM_READ on `start` with a memory operand.
- REG_EXEC→IDLE.
- MEM_READ→MEM_MODIFY.
- MEM_MODIFY→MEM_WRITE.
- MEM_WRITE→IDLE.

Top module: `bitprefix_exec`

## Requirements
- R1: Opcode bits 7:6 select the group: 0 rotate/shift, 1 bit test, 2 bit clear, 3 bit set. Bits 5:3 give the bit number, or for group 0 the operation. Bits 2:0 give the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A. The register index on the register-file ports uses that same numbering.
- R2: A register operand, not indexed, raises `done` in the first cycle after `start`. In that cycle the result is written to `rf_waddr` equal to bits 2:0, and `states_used` reads 8.
- R3: A memory operand reads `mem_addr` in the first cycle after `start` and captures the byte in the second. In the third cycle it writes to the same address, raises `done` and reports `states_used` = 12. Read and write never coincide.
- R4: In indexed mode the operand is the memory byte whatever bits 2:0 hold. When bits 2:0 are not 6, the result is also written to that register in the same cycle as the memory write. When they are 6, no register write occurs.
- R5: Bit test writes no register and no memory. Its flags (bit 7 down to 0 = S,Z,5,H,3,P/V,N,C) are:
  - Z and P/V are the inverse of the tested bit.
  - H is 1 and N is 0.
  - S is 1 only when bit 7 is tested and is 1.
  - Bits 5 and 3 copy the operand.
  - C keeps its previous value.
- R6: Bit clear and bit set change only the selected bit and do not write the flags (`flags_we` stays low).
- R7: Rotate/shift selects by bits 5:3. The operations and the bit shifted in are:
  - 0 rotate left circular; 1 rotate right circular.
  - 2 rotate left through carry; 3 rotate right through carry.
  - 4 shift left with 0 in; 5 arithmetic shift right.
  - 6 shift left with 1 in; 7 logical shift right.
- R8: Rotate/shift flags are:
  - S, bit 5 and bit 3 copy the result.
  - Z is set when the result is zero.
  - P/V is 1 for even parity.
  - H and N are 0.
  - C is the bit shifted out.
- R9: `done` is high for exactly one cycle per instruction. `start`, `opcode` and `addr` changes while busy are ignored.
- R10: During reset `done`, `rf_we`, `mem_re`, `mem_we` and `flags_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled in idle) |
| opcode | input | 8 | Bit-page opcode |
| indexed | input | 1 | Indexed mode: memory operand plus register copy |
| addr | input | ADDR_W | Memory operand address |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |
| flags_in | input | 8 | Current flag register |
| flags_we | output | 1 | Flag register write enable |
| flags_out | output | 8 | New flag value |
| mem_addr | output | ADDR_W | Memory address |
| mem_re | output | 1 | Memory read request (data next cycle) |
| mem_rdata | input | 8 | Memory read data |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle completion pulse |
| states_used | output | CNT_W | Machine states charged, valid with `done` |

## Verification
In indexed mode, the memory write-back and the register copy fall in the same cycle. The flag update joins them for rotate/shift operations. The bench provokes this with indexed rotate, clear and set instructions on every register field. In the write cycle it requires `mem_we` and `rf_we` together with identical data, then compares memory, register file and flags against its own model. Indexed field 6 and indexed bit test are used to judge the cases where the register copy must stay absent.

// File: rtl/bitprefix_pkg.sv
package bitprefix_pkg;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 3;
    localparam logic [IDX_W-1:0] OPND_MEM = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REG_EXEC,
        ST_MEM_READ,
        ST_MEM_MODIFY,
        ST_MEM_WRITE
    } exec_state_t;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLEAR = 2'd2,
        GRP_SET   = 2'd3
    } op_group_t;
endpackage

// File: rtl/rot_shift_unit.sv
module rot_shift_unit
    import bitprefix_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    input  logic [2:0]        sel,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    always_comb begin
        res  = val;
        cout = 1'b0;
        unique case (sel)
            3'd0: begin res = {val[DATA_W-2:0], val[DATA_W-1]}; cout = val[DATA_W-1]; end
            3'd1: begin res = {val[0], val[DATA_W-1:1]};        cout = val[0];        end
            3'd2: begin res = {val[DATA_W-2:0], cin};           cout = val[DATA_W-1]; end
            3'd3: begin res = {cin, val[DATA_W-1:1]};           cout = val[0];        end
            3'd4: begin res = {val[DATA_W-2:0], 1'b0};          cout = val[DATA_W-1]; end
            3'd5: begin res = {val[DATA_W-1], val[DATA_W-1:1]}; cout = val[0];        end
            3'd6: begin res = {val[DATA_W-2:0], 1'b1};          cout = val[DATA_W-1]; end
            3'd7: begin res = {1'b0, val[DATA_W-1:1]};          cout = val[0];        end
        endcase
    end
endmodule

// File: rtl/bit_alu.sv
module bit_alu
    import bitprefix_pkg::*;
(
    input  logic [7:0]        op,
    input  logic [DATA_W-1:0] val,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] res,
    output logic [7:0]        flags_out,
    output logic              res_wr,
    output logic              flags_wr
);
    op_group_t         grp;
    logic [2:0]        bsel;
    logic [DATA_W-1:0] mask;
    logic              tested;
    logic [DATA_W-1:0] rs_res;
    logic              rs_co;

    assign grp    = op_group_t'(op[7:6]);
    assign bsel   = op[5:3];
    assign mask   = DATA_W'(1) << bsel;
    assign tested = val[bsel];

    rot_shift_unit u_rs (
        .val  (val),
        .cin  (flags_in[0]),
        .sel  (bsel),
        .res  (rs_res),
        .cout (rs_co)
    );

    always_comb begin
        res       = val;
        flags_out = flags_in;
        res_wr    = 1'b0;
        flags_wr  = 1'b0;
        unique case (grp)
            GRP_SHIFT: begin
                res       = rs_res;
                flags_out = {rs_res[7], (rs_res == '0), rs_res[5], 1'b0,
                             rs_res[3], ~^rs_res, 1'b0, rs_co};
                res_wr    = 1'b1;
                flags_wr  = 1'b1;
            end
            GRP_TEST: begin
                flags_out = {(bsel == 3'd7) && tested, ~tested, val[5], 1'b1,
                             val[3], ~tested, 1'b0, flags_in[0]};
                flags_wr  = 1'b1;
            end
            GRP_CLEAR: begin
                res    = val & ~mask;
                res_wr = 1'b1;
            end
            GRP_SET: begin
                res    = val | mask;
                res_wr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bitprefix_exec.sv
module bitprefix_exec
    import bitprefix_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 8,
    parameter int BASE_STATES = 8,
    parameter int MEM_EXTRA   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic              indexed,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        rf_raddr,
    input  logic [7:0]        rf_rdata,
    output logic              rf_we,
    output logic [2:0]        rf_waddr,
    output logic [7:0]        rf_wdata,
    input  logic [7:0]        flags_in,
    output logic              flags_we,
    output logic [7:0]        flags_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic [CNT_W-1:0]  states_used
);
    localparam logic [CNT_W-1:0] REG_COST = CNT_W'(BASE_STATES);
    localparam logic [CNT_W-1:0] MEM_COST = CNT_W'(BASE_STATES + MEM_EXTRA);

    exec_state_t       state, state_nx;
    logic [7:0]        op_q;
    logic              idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mem_val_q;
    logic              mem_opnd;

    logic [DATA_W-1:0] operand, alu_res;
    logic [7:0]        alu_flags;
    logic              alu_res_wr, alu_flags_wr;

    assign mem_opnd = indexed || (opcode[2:0] == OPND_MEM);
    assign operand  = (state == ST_REG_EXEC) ? rf_rdata : mem_val_q;

    bit_alu u_alu (
        .op        (op_q),
        .val       (operand),
        .flags_in  (flags_in),
        .res       (alu_res),
        .flags_out (alu_flags),
        .res_wr    (alu_res_wr),
        .flags_wr  (alu_flags_wr)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start) state_nx = mem_opnd ? ST_MEM_READ : ST_REG_EXEC;
            ST_REG_EXEC:   state_nx = ST_IDLE;
            ST_MEM_READ:   state_nx = ST_MEM_MODIFY;
            ST_MEM_MODIFY: state_nx = ST_MEM_WRITE;
            ST_MEM_WRITE:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= '0;
            idx_q     <= 1'b0;
            addr_q    <= '0;
            mem_val_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                op_q   <= opcode;
                idx_q  <= indexed;
                addr_q <= addr;
            end
            if (state == ST_MEM_MODIFY) mem_val_q <= mem_rdata;
        end
    end

    always_comb begin
        rf_raddr    = op_q[2:0];
        rf_waddr    = op_q[2:0];
        rf_wdata    = alu_res;
        mem_wdata   = alu_res;
        mem_addr    = addr_q;
        flags_out   = alu_flags;
        rf_we       = 1'b0;
        flags_we    = 1'b0;
        mem_re      = 1'b0;
        mem_we      = 1'b0;
        done        = 1'b0;
        states_used = '0;
        unique case (state)
            ST_IDLE: ;
            ST_REG_EXEC: begin
                rf_we       = alu_res_wr;
                flags_we    = alu_flags_wr;
                done        = 1'b1;
                states_used = REG_COST;
            end
            ST_MEM_READ:   mem_re = 1'b1;
            ST_MEM_MODIFY: ;
            ST_MEM_WRITE: begin
                mem_we      = alu_res_wr;
                rf_we       = alu_res_wr && idx_q && (op_q[2:0] != OPND_MEM);
                flags_we    = alu_flags_wr;
                done        = 1'b1;
                states_used = MEM_COST;
            end
        endcase
    end
endmodule

// File: rtl/bitprefix_exec_chk.sv
module bitprefix_exec_chk
    import bitprefix_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 8,
    parameter int BASE_STATES = 8,
    parameter int MEM_EXTRA   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input exec_state_t       state,
    input logic [7:0]        op_q,
    input logic              rf_we,
    input logic [2:0]        rf_waddr,
    input logic [7:0]        rf_wdata,
    input logic [7:0]        flags_in,
    input logic              flags_we,
    input logic [7:0]        flags_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input logic [7:0]        mem_wdata,
    input logic              done,
    input logic [CNT_W-1:0]  states_used
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_rw_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    p_rmw_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_re, 2) && mem_addr == $past(mem_addr, 2)));

    p_mem_cost_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state == ST_MEM_WRITE) |-> states_used == CNT_W'(BASE_STATES + MEM_EXTRA));

    p_reg_cost_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state == ST_REG_EXEC) |-> states_used == CNT_W'(BASE_STATES));

    p_idx_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && state == ST_MEM_WRITE) |-> (mem_we && rf_wdata == mem_wdata && rf_waddr != OPND_MEM));

    p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && op_q[7:6] == 2'd1) |-> (!rf_we && !mem_we));

    p_test_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && op_q[7:6] == 2'd1) |-> flags_out[0] == flags_in[0]);

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && op_q[7]) |-> !flags_we);
endmodule

bind bitprefix_exec bitprefix_exec_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_STATES(BASE_STATES), .MEM_EXTRA(MEM_EXTRA)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .op_q(op_q),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .flags_in(flags_in), .flags_we(flags_we), .flags_out(flags_out),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .done(done), .states_used(states_used)
);

// File: tb/bitprefix_exec_tb.sv
`timescale 1ns/1ps
module bitprefix_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic        indexed = 1'b0;
    logic [15:0] addr = '0;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [7:0]  rf_rdata, rf_wdata, flags_out, mem_wdata;
    logic        rf_we, flags_we, mem_re, mem_we, done;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  states_used;

    logic [7:0] rf [8];
    logic [7:0] mem [256];
    logic [7:0] fl;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bitprefix_exec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .indexed(indexed),
        .addr(addr), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .flags_in(fl), .flags_we(flags_we),
        .flags_out(flags_out), .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .done(done), .states_used(states_used)
    );

    assign rf_rdata = rf[rf_raddr];

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (flags_we) fl <= flags_out;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input int op, input int v, input int f,
                                  output int r, output int nf, output bit rw, output bit fw);
        int n, co, b;
        n = (op / 8) % 8;
        r = v; nf = f; rw = 0; fw = 0; co = 0;
        case (op / 64)
            0: begin
                case (n)
                    0: begin co = v / 128; r = (v * 2 + co) % 256; end
                    1: begin co = v % 2; r = v / 2 + co * 128; end
                    2: begin co = v / 128; r = (v * 2 + f % 2) % 256; end
                    3: begin co = v % 2; r = v / 2 + (f % 2) * 128; end
                    4: begin co = v / 128; r = (v * 2) % 256; end
                    5: begin co = v % 2; r = v / 2 + (v / 128) * 128; end
                    6: begin co = v / 128; r = (v * 2 + 1) % 256; end
                    default: begin co = v % 2; r = v / 2; end
                endcase
                nf = (r & 'hA8) + ((r == 0) ? 64 : 0) + (($countones(r[7:0]) % 2 == 0) ? 4 : 0) + co;
                rw = 1; fw = 1;
            end
            1: begin
                b = (v >> n) & 1;
                nf = (f & 1) + (v & 'h28) + 16 + ((b == 0) ? 'h44 : 0) + ((n == 7 && b == 1) ? 128 : 0);
                fw = 1;
            end
            2: begin r = v & ~(1 << n) & 255; rw = 1; end
            default: begin r = v | (1 << n); rw = 1; end
        endcase
    endfunction

    task automatic run_op(input int op, input bit idx, input int a, input bit poke);
        int v, r, nf, lat, fld;
        bit rw, fw, memop;
        logic [7:0] erf [8];
        logic [7:0] emem;
        fld = op % 8;
        memop = idx || fld == 6;
        v = memop ? int'(mem[a]) : int'(rf[fld]);
        model(op, v, int'(fl), r, nf, rw, fw);
        for (int i = 0; i < 8; i++) erf[i] = rf[i];
        emem = mem[a];
        if (rw && !memop) erf[fld] = 8'(r);
        if (rw && memop) emem = 8'(r);
        if (rw && idx && fld != 6) erf[fld] = 8'(r);
        lat = memop ? 3 : 1;
        start = 1; opcode = 8'(op); indexed = idx; addr = 16'(a);
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            if (k == 1 && poke) begin start = 1; opcode = 8'hFF; addr = 16'h00F0; end
            else start = 0;
            chk(done == (k == lat), "R9 done timing", done, k == lat);
            chk(mem_re == (memop && k == 1), "R3 read cycle", mem_re, memop && k == 1);
            chk(mem_we == (memop && rw && k == 3), "R3 write cycle", mem_we, memop && rw && k == 3);
            if (k == lat) begin
                chk(states_used == (memop ? 12 : 8), memop ? "R3 states" : "R2 states",
                    states_used, memop ? 12 : 8);
                chk(flags_we == fw, "R6 flag write enable", flags_we, fw);
                if (memop && rw) chk(mem_addr == 16'(a), "R3 same address", mem_addr, a);
                if (idx && rw && fld != 6)
                    chk(rf_we && mem_we && rf_wdata == mem_wdata && rf_waddr == 3'(fld),
                        "R4 copy with memory write", rf_wdata, mem_wdata);
                else if (memop)
                    chk(!rf_we, "R4 no register copy", rf_we, 0);
            end
        end
        start = 0;
        for (int i = 0; i < 8; i++) chk(rf[i] == erf[i], "R1 register file", rf[i], erf[i]);
        chk(mem[a] == emem, "R3 memory byte", mem[a], emem);
        chk(fl == 8'(nf), (op / 64 == 1) ? "R5 bit test flags" : "R8 flags", fl, nf);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 8'(8'h11 * i + 3);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        fl = 8'h00;
        repeat (3) @(negedge clk);
        chk(!done && !rf_we && !mem_re && !mem_we && !flags_we, "R10 reset outputs",
            {done, rf_we, mem_re, mem_we, flags_we}, 0);
        rst_n = 1;
        @(negedge clk);
        rf[0] = 8'h81; run_op('h00, 0, 0, 0);           // R7 rotate left circular B
        rf[1] = 8'h01; run_op('h09, 0, 0, 0);           // R7 rotate right circular C
        fl = 8'h01; rf[2] = 8'h40; run_op('h12, 0, 0, 0); // R7 through carry
        rf[3] = 8'h01; run_op('h1B, 0, 0, 0);           // R8 zero and carry
        rf[5] = 8'h82; run_op('h2D, 0, 0, 0);           // R7 arithmetic right
        rf[7] = 8'h00; run_op('h37, 0, 0, 0);           // R7 shift left with one
        rf[7] = 8'hF0; run_op('h7F, 0, 0, 0);           // R5 bit 7 set, S flag
        rf[0] = 8'hFE; run_op('h40, 0, 0, 0);           // R5 bit 0 clear
        run_op('h46, 0, 16, 0);                         // R5 memory test, no write
        rf[4] = 8'hFF; run_op('hA4, 0, 0, 0);           // R6 clear bit 4 of H
        run_op('hFE, 0, 32, 1);                         // R9 start during busy ignored
        run_op('hD9, 1, 48, 0);                         // R4 indexed set, copy to C
        run_op('h9E, 1, 49, 0);                         // R4 indexed field 6, no copy
        run_op('h5A, 1, 50, 0);                         // R4/R5 indexed test
        run_op('h1F, 1, 51, 0);                         // R4 indexed rotate to A
        for (int op = 0; op < 256; op++) begin          // R1 full opcode sweep
            rf[op % 8] = 8'(op * 13 + 7);
            run_op(op, 0, op % 64 + 64, 0);
        end
        for (int op = 0; op < 256; op += 3) begin       // R4 indexed sweep
            run_op(op, 1, op % 64 + 128, 0);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule